// File: doc/BRIEF.md
# Comparator event conditioner

This block takes the one-bit output of an analog comparator and derives two events from it: an interrupt request for software and a trigger for an ADC. The raw input is first brought into the clock domain through a flop chain. An optional inversion then produces the conditioned comparator value, which feeds two detectors that are configured separately. Each detector can work in level mode with its own polarity, or react to falling, rising or either edges.

Software sees four byte-wide locations through a simple write/read port. They hold the control fields, an interrupt enable, a write-one-to-clear interrupt status, and a read-only view of the live state. Reconfiguring the inversion or a sense field never produces an edge that the comparator did not make.

Top module: `cmp_event_cond`

## Requirements
- R1: Address 0 holds the control byte: bit 1 invert, bits 3:2 interrupt sense, bit 4 interrupt level value, bits 6:5 trigger sense, bit 7 trigger level value. Bit 0 always reads 0, and writes to it are ignored.
- R2: Both sense fields use the same code: 0 level, 1 falling edge, 2 rising edge, 3 either edge. A detector in level mode never reports an edge.
- R3: The raw input passes through SYNC_STAGES flops. The conditioned value is the synchronised value XOR the invert bit, and it reads back at address 3 bit 0.
- R4: With trigger sense 1, 2 or 3, `trig_o` is high for exactly the cycle in which the conditioned value differs from its previous value in the selected direction.
- R5: With trigger sense 0, `trig_o` is high in every cycle where the conditioned value equals the trigger level value.
- R6: With interrupt sense 1, 2 or 3, a qualifying edge sets the status bit (address 2 bit 0). The bit stays set until a write with data bit 0 set to address 2. A set in the same cycle as a clear wins, and writing 0 has no effect.
- R7: With interrupt sense 0, the status bit in each cycle equals whether the conditioned value matched the interrupt level value in the previous cycle. A write-one-to-clear therefore cannot remove it while the match holds.
- R8: `irq_o` equals the status bit ANDed with the enable bit at address 1 bit 0.
- R9: In a cycle that writes address 0, both detectors report no edge. The previous-value register takes the input as conditioned by the new invert bit, so a change of inversion creates no edge.
- R10: Address 3 reads bit 0 conditioned value, bit 1 raw status, bit 2 masked status, with all other bits 0. Address 1 and address 2 read only their bit 0.
- R11: After reset every register field, the status bit and the synchroniser are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Unsynchronised comparator output |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Masked interrupt request |
| trig_o | output | 1 | ADC trigger event |

## Verification
The bench builds the block with its defaults: two synchroniser stages, an 8-bit data path and a 2-bit address. With these values all four locations, every field and every combination of the two sense codes can be reached. Because the input-to-event latency is only two cycles, a random input can toggle every cycle and still produce back-to-back edges. Random control writes collide with input edges and with write-one-to-clear, which reaches both the suppressed-edge cycle and the case where a set and a clear fall in the same cycle.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

   typedef enum logic [1:0] {
      SNS_LEVEL = 2'd0,
      SNS_FALL  = 2'd1,
      SNS_RISE  = 2'd2,
      SNS_BOTH  = 2'd3
   } sense_e;

   // bit 7 down to bit 0
   typedef struct packed {
      logic   trig_lvl;
      sense_e trig_sns;
      logic   int_lvl;
      sense_e int_sns;
      logic   invert;
      logic   rsvd;
   } ctrl_t;

   localparam int CTRL_W   = $bits(ctrl_t);
   localparam int ADR_CTRL = 0;
   localparam int ADR_MASK = 1;
   localparam int ADR_STAT = 2;
   localparam int ADR_VIEW = 3;
   localparam int N_DET    = 2;   // 0: interrupt, 1: trigger

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cmp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_sense.sv
module cmp_sense
   import cmp_evt_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cur_i,
   input  logic   prev_i,
   input  sense_e mode_i,
   input  logic   lvl_i,
   input  logic   hold_i,
   output logic   lvl_hit_o,
   output logic   edge_hit_o
);
   logic rise, fall;

   assign rise = cur_i & ~prev_i;
   assign fall = ~cur_i & prev_i;

   always_comb begin
      lvl_hit_o = (mode_i == SNS_LEVEL) && (cur_i == lvl_i);
      unique case (mode_i)
         SNS_FALL: edge_hit_o = fall;
         SNS_RISE: edge_hit_o = rise;
         SNS_BOTH: edge_hit_o = rise | fall;
         default:  edge_hit_o = 1'b0;
      endcase
      if (hold_i) edge_hit_o = 1'b0;
   end

   // R4: an edge report always corresponds to a real change of the conditioned value
   a_r4_real_edge: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit_o |-> (cur_i != prev_i));

   // R2: level mode and edge reports are exclusive
   a_r2_mode_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SNS_LEVEL) |-> !edge_hit_o);
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
   import cmp_evt_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              stat_i,
   input  logic              cond_i,
   output ctrl_t             ctrl_q,
   output ctrl_t             ctrl_nxt,
   output logic              ctrl_wr,
   output logic              mask_q,
   output logic              clr_o,
   output logic [DATA_W-1:0] rd_data_o
);
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("cmp_regs: DATA_W must hold the control byte");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("cmp_regs: ADDR_W must reach four locations");
   end

   logic mask_wr;

   assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
   assign mask_wr  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_MASK));
   assign clr_o    = wr_en_i && (wr_addr_i == ADDR_W'(ADR_STAT)) && wr_data_i[0];
   assign ctrl_nxt = ctrl_t'({wr_data_i[CTRL_W-1:1], 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= ctrl_nxt;
         if (mask_wr) mask_q <= wr_data_i[0];
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_W'(ADR_CTRL))
         rd_data_o[CTRL_W-1:0] = ctrl_q;
      else if (rd_addr_i == ADDR_W'(ADR_MASK))
         rd_data_o[0] = mask_q;
      else if (rd_addr_i == ADDR_W'(ADR_STAT))
         rd_data_o[0] = stat_i;
      else if (rd_addr_i == ADDR_W'(ADR_VIEW))
         rd_data_o[2:0] = {stat_i & mask_q, stat_i, cond_i};
   end

   // R1: the reserved bit never holds a 1
   a_r1_rsvd_low: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ctrl_q.rsvd == 1'b0));
endmodule

// File: rtl/cmp_event_cond.sv
module cmp_event_cond
   import cmp_evt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_raw_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o,
   output logic              trig_o
);
   ctrl_t  ctrl_q, ctrl_nxt;
   logic   ctrl_wr, mask_q, clr;
   logic   sync_q, cond, prev_q, stat_q, stat_nxt;
   sense_e det_mode [N_DET];
   logic   det_lvl  [N_DET];
   logic   lvl_hit  [N_DET];
   logic   edge_hit [N_DET];

   cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_raw_i),
      .q_o   (sync_q)
   );

   cmp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_addr_i (rd_addr_i),
      .stat_i    (stat_q),
      .cond_i    (cond),
      .ctrl_q    (ctrl_q),
      .ctrl_nxt  (ctrl_nxt),
      .ctrl_wr   (ctrl_wr),
      .mask_q    (mask_q),
      .clr_o     (clr),
      .rd_data_o (rd_data_o)
   );

   assign cond = sync_q ^ ctrl_q.invert;

   // previous value re-based on the new inversion during a control write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= 1'b0;
      else if (ctrl_wr) prev_q <= sync_q ^ ctrl_nxt.invert;
      else              prev_q <= cond;
   end

   assign det_mode[0] = ctrl_q.int_sns;
   assign det_lvl[0]  = ctrl_q.int_lvl;
   assign det_mode[1] = ctrl_q.trig_sns;
   assign det_lvl[1]  = ctrl_q.trig_lvl;

   for (genvar k = 0; k < N_DET; k++) begin : g_det
      cmp_sense i_sense (
         .clk        (clk),
         .rst_n      (rst_n),
         .cur_i      (cond),
         .prev_i     (prev_q),
         .mode_i     (det_mode[k]),
         .lvl_i      (det_lvl[k]),
         .hold_i     (ctrl_wr),
         .lvl_hit_o  (lvl_hit[k]),
         .edge_hit_o (edge_hit[k])
      );
   end

   always_comb begin
      if (ctrl_q.int_sns == SNS_LEVEL) stat_nxt = lvl_hit[0];
      else                             stat_nxt = edge_hit[0] | (stat_q & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= stat_nxt;
   end

   assign trig_o = lvl_hit[1] | edge_hit[1];
   assign irq_o  = stat_q & mask_q;

   // R6: in edge mode the status bit survives every cycle without a clear
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.int_sns != SNS_LEVEL && stat_q && !clr) |=> stat_q);

   // R7: in level mode the status bit tracks the previous cycle's match
   a_r7_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.int_sns == SNS_LEVEL) |=> (stat_q == $past(cond == ctrl_q.int_lvl)));

   // R8: no request leaves the block while the enable is off
   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q |-> !irq_o);

   // R9: a control write never fires an edge-mode trigger
   a_r9_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_q.trig_sns != SNS_LEVEL) |-> !trig_o);
endmodule

// File: tb/test_cmp_event_cond.sv
`timescale 1ns/1ps
module test_cmp_event_cond;
   localparam int AW = 2;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_raw = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq, trig;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   string tag_force = "";

   // bench model state
   bit       m_s1, m_s2, m_prev, m_stat, m_mask;
   bit [7:0] m_ctrl;

   always #10 clk = ~clk;   // 50 MHz

   cmp_event_cond #(.SYNC_STAGES(2), .ADDR_W(AW), .DATA_W(DW)) i_cmp_event_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_raw_i (cmp_raw),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .irq_o     (irq),
      .trig_o    (trig)
   );

   function automatic bit edge_of(bit [1:0] mode, bit cur, bit prev);
      case (mode)
         2'd1:    return prev & ~cur;
         2'd2:    return ~prev & cur;
         2'd3:    return prev ^ cur;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit m_cond();
      return m_s2 ^ m_ctrl[1];
   endfunction

   function automatic bit ctrl_write();
      return wr_en && wr_addr == 2'd0;
   endfunction

   function automatic bit exp_trig();
      if (m_ctrl[6:5] == 2'd0) return m_cond() == m_ctrl[7];
      return !ctrl_write() && edge_of(m_ctrl[6:5], m_cond(), m_prev);
   endfunction

   function automatic bit [7:0] exp_rd(bit [1:0] a);
      case (a)
         2'd0:    return {m_ctrl[7:1], 1'b0};
         2'd1:    return {7'd0, m_mask};
         2'd2:    return {7'd0, m_stat};
         default: return {5'd0, m_stat & m_mask, m_stat, m_cond()};
      endcase
   endfunction

   task automatic check(string tag, int got, int exp);
      string t = (tag_force != "") ? tag_force : tag;
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_mask = 0; m_ctrl = '0;
   endtask

   task automatic model_step();
      bit cw  = ctrl_write();
      bit clr = wr_en && wr_addr == 2'd2 && wr_data[0];
      bit cur = m_cond();
      bit ei  = !cw && edge_of(m_ctrl[3:2], cur, m_prev);
      bit nstat, nprev;
      if (m_ctrl[3:2] == 2'd0) nstat = (cur == m_ctrl[4]);
      else                     nstat = ei | (m_stat & ~clr);
      nprev = cw ? (m_s2 ^ wr_data[1]) : cur;
      m_stat = nstat;
      m_prev = nprev;
      m_s2 = m_s1;
      m_s1 = cmp_raw;
      if (cw) m_ctrl = {wr_data[7:1], 1'b0};
      if (wr_en && wr_addr == 2'd1) m_mask = wr_data[0];
   endtask

   // inputs are already applied at a falling edge
   task automatic cyc();
      #2;
      check((m_ctrl[6:5] == 2'd0) ? "R5" : "R4", trig, exp_trig());
      check("R8", irq, m_stat & m_mask);
      case (rd_addr)
         2'd0:    check("R1", rd_data, exp_rd(rd_addr));
         2'd1:    check("R10", rd_data, exp_rd(rd_addr));
         2'd2:    check((m_ctrl[3:2] == 2'd0) ? "R7" : "R6", rd_data, exp_rd(rd_addr));
         default: check("R10", rd_data, exp_rd(rd_addr));
      endcase
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic drive(bit we, bit [1:0] wa, bit [7:0] wd, bit [1:0] ra, bit cin);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; cmp_raw = cin;
      cyc();
   endtask

   task automatic print_summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         print_summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state of every location
      tag_force = "R11";
      for (int a = 0; a < 4; a++) drive(0, 0, 0, 2'(a), 0);

      // R3: synchroniser latency and inversion, read through the view
      tag_force = "R3";
      for (int i = 0; i < 4; i++) drive(0, 0, 0, 3, 1);
      drive(1, 0, 8'h02, 3, 1);
      for (int i = 0; i < 3; i++) drive(0, 0, 0, 3, 0);

      // R2: every sense code on both detectors with a toggling input
      tag_force = "R2";
      drive(1, 1, 8'h01, 1, 0);
      for (int m = 0; m < 4; m++) begin
         drive(1, 0, 8'(m << 5 | m << 2 | (m & 1) << 4 | (m & 1) << 7), 0, 0);
         for (int i = 0; i < 8; i++) drive(i == 5, 2, 8'h01, 2'(i & 3), bit'((i >> 1) & 1));
      end

      // R9: flipping the inversion on a steady input makes no edge
      tag_force = "R9";
      drive(1, 0, 8'h6C, 2, 0);
      drive(1, 2, 8'h01, 2, 0);
      for (int i = 0; i < 3; i++) drive(0, 0, 0, 3, 0);
      drive(1, 0, 8'h6E, 3, 0);
      for (int i = 0; i < 3; i++) drive(0, 0, 0, 3, 0);
      drive(1, 0, 8'h6C, 3, 0);
      for (int i = 0; i < 3; i++) drive(0, 0, 0, 3, 0);

      // R6 / R7: clear attempts in edge and level modes
      tag_force = "";
      drive(1, 0, 8'h08, 2, 0);
      for (int i = 0; i < 4; i++) drive(0, 0, 0, 2, 1);
      drive(1, 2, 8'h00, 2, 1);      // writing 0 does nothing
      drive(1, 2, 8'h01, 2, 1);      // clear
      drive(0, 0, 0, 2, 1);
      drive(1, 0, 8'h10, 2, 1);      // level mode, value 1
      for (int i = 0; i < 3; i++) drive(1, 2, 8'h01, 2, 1);

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         bit          we  = ($urandom % 8) == 0;
         bit [1:0]    wa  = 2'($urandom % 3);
         bit [7:0]    wd  = 8'($urandom);
         bit          cin = (($urandom % 3) == 0) ? ~cmp_raw : cmp_raw;
         drive(we, wa, wd, 2'($urandom % 4), cin);
      end

      done = 1'b1;
      print_summary();
      $finish;
   end
endmodule